// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low modem handshake inputs (clear-to-send, data-set-ready, ring indicator, carrier detect) and presents them to a host as one status byte. The upper half of the byte carries the present active-high level of each line. The lower half carries a sticky change flag per line. The flags stay set until the host reads the byte. An interrupt request stays high while any flag is set.

The external pins pass through a synchroniser before any comparison is made. A loop-back input swaps the synchronised pins for the port's own four output control bits, which are request-to-send, data-terminal-ready and two auxiliary outputs. Change detection runs on whichever source is selected, so switching the source can raise flags. Three lines flag a change in either direction. The ring line flags only the end of a ring, when its active-low pin returns from 0 to 1. A read strobe of one cycle clears the flags at the next clock edge.

Top module: `modem_stat_watch`

## Requirements
- R1: With `loop_en` low, `status[4+i]` equals the inverse of `pin_n[i]`, three rising clock edges after the pin changes (two synchroniser stages plus one status register). Lines are indexed 0 = clear-to-send, 1 = data-set-ready, 2 = ring, 3 = carrier detect.
- R2: With `loop_en` high, `status[4+i]` equals `ctl_out[i]` one clock edge later. `ctl_out` bit 0 = request-to-send, bit 1 = data-terminal-ready, bits 2 and 3 = auxiliary outputs.
- R3: `status[0]`, `status[1]` and `status[3]` are set when their line's level changes in either direction.
- R4: `status[2]` is set only when the ring level falls from 1 to 0 (the pin goes from 0 to 1). A rise of the ring level leaves it clear.
- R5: A one-cycle `rd_stb` clears every change flag at the next clock edge when no new change arrives in that cycle.
- R6: A change detected in the same cycle as `rd_stb` leaves its flag set after the read. The other flags clear.
- R7: `irq` is high exactly while at least one of `status[3:0]` is 1.
- R8: Turning `loop_en` on or off counts as a level change for every line whose selected source differs from the previous level. Lines whose source does not differ raise no flag.
- R9: Reset is synchronous and active low. During reset and after it, all flags are 0 and the level bits show the present inputs. Holding the inputs steady across reset release raises no flag.
- R10: A set flag stays set, with no read, through any number of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_n | input | 4 | Active-low modem inputs: 0 CTS, 1 DSR, 2 ring, 3 carrier detect |
| loop_en | input | 1 | Selects the control bits instead of the pins |
| ctl_out | input | 4 | Port output controls: 0 RTS, 1 DTR, 2 aux1, 3 aux2 |
| rd_stb | input | 1 | Host read of the status byte; clears the flags |
| status | output | 8 | {levels[3:0], change flags[3:0]} |
| irq | output | 1 | High while any change flag is set |

## Verification
The host read and a fresh line change can land on the same clock edge. The read must then clear only the older flags and keep the new one. A directed case sets two flags through loop-back, then changes the ring source in the very cycle `rd_stb` is high, and expects exactly the ring flag to remain. The random phase drives pin flips, control changes, loop-back toggles and reads together at high rates, so coincident reads and events happen many times. Every cycle's status byte is compared with a model in the bench that is built from the requirements.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
   typedef enum logic {
      EDGE_ANY  = 1'b0,
      EDGE_FALL = 1'b1
   } edge_mode_e;

   localparam int unsigned LINE_CTS = 0;
   localparam int unsigned LINE_DSR = 1;
   localparam int unsigned LINE_RNG = 2;
   localparam int unsigned LINE_DCD = 3;
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mstat_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("mstat_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   // Reset loads the raw input into every stage, so the chain starts settled.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= d;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mstat_src_sel.sv
module mstat_src_sel #(
   parameter int unsigned W = 4
) (
   input  logic         loop_en,
   input  logic [W-1:0] pin_sync_n,
   input  logic [W-1:0] ctl,
   output logic [W-1:0] lvl
);
   always_comb begin
      if (loop_en) lvl = ctl;
      else         lvl = ~pin_sync_n;
   end
endmodule

// File: rtl/mstat_flag.sv
module mstat_flag
   import mstat_pkg::*;
#(
   parameter edge_mode_e MODE = EDGE_ANY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic rd,
   output logic lvl_q,
   output logic flag_q
);
   logic ev;

   if (MODE == EDGE_FALL) begin : g_fall
      assign ev = lvl_q & ~lvl;
   end else begin : g_any
      assign ev = lvl_q ^ lvl;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q  <= lvl;
         flag_q <= 1'b0;
      end else begin
         lvl_q  <= lvl;
         flag_q <= rd ? ev : (flag_q | ev);
      end
   end

   // R5: a read with no new change empties the flag
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (lvl == lvl_q)) |=> !flag_q);

   // R10: without a read the flag is held
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !rd) |=> flag_q);

   if (MODE == EDGE_FALL) begin : g_chk_fall
      // R4: a rising level never raises a clear flag
      a_r4_rise_ignored: assert property (@(posedge clk) disable iff (!rst_n)
         (!flag_q && lvl && !lvl_q) |=> !flag_q);
      // R4: a falling level always raises the flag
      a_r4_fall_flags: assert property (@(posedge clk) disable iff (!rst_n)
         (!lvl && lvl_q) |=> flag_q);
   end else begin : g_chk_any
      // R3 and R6: any level difference, read or not, leaves the flag set
      a_r3_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
         (lvl != lvl_q) |=> flag_q);
   end
endmodule

// File: rtl/modem_stat_watch.sv
module modem_stat_watch
   import mstat_pkg::*;
#(
   parameter int unsigned          SYNC_STAGES = 2,
   parameter int unsigned          NUM_LINES   = 4,
   parameter logic [NUM_LINES-1:0] FALL_MASK   = 4'b0100
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_LINES-1:0]   pin_n,
   input  logic                   loop_en,
   input  logic [NUM_LINES-1:0]   ctl_out,
   input  logic                   rd_stb,
   output logic [2*NUM_LINES-1:0] status,
   output logic                   irq
);
   localparam int unsigned STAT_W = 2 * NUM_LINES;

   if (NUM_LINES < 1) begin : g_bad_lines
      $error("modem_stat_watch: NUM_LINES must be at least 1");
   end

   logic [NUM_LINES-1:0] pin_sync_n;
   logic [NUM_LINES-1:0] sel_lvl;
   logic [NUM_LINES-1:0] lvl_q;
   logic [NUM_LINES-1:0] flag_q;

   mstat_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_n),
      .q     (pin_sync_n)
   );

   mstat_src_sel #(.W(NUM_LINES)) u_sel (
      .loop_en    (loop_en),
      .pin_sync_n (pin_sync_n),
      .ctl        (ctl_out),
      .lvl        (sel_lvl)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      if (FALL_MASK[i]) begin : g_fall
         mstat_flag #(.MODE(EDGE_FALL)) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl    (sel_lvl[i]),
            .rd     (rd_stb),
            .lvl_q  (lvl_q[i]),
            .flag_q (flag_q[i])
         );
      end else begin : g_any
         mstat_flag #(.MODE(EDGE_ANY)) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl    (sel_lvl[i]),
            .rd     (rd_stb),
            .lvl_q  (lvl_q[i]),
            .flag_q (flag_q[i])
         );
      end
   end

   assign status = {lvl_q, flag_q};
   assign irq    = |flag_q;

   // R2: in loop-back the level half follows the control bits one edge later
   a_r2_loop_follow: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en |=> (status[STAT_W-1:NUM_LINES] == $past(ctl_out)));

   // R7: a rise of the request needs a flag that was clear before
   a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(status[NUM_LINES-1:0]) == '0));

   // R9: the edge after a reset cycle shows no flag
   a_r9_reset_clean: assert property (@(posedge clk)
      !rst_n |=> (status[NUM_LINES-1:0] == '0));
endmodule

// File: tb/tb_modem_stat_watch.sv
module tb_modem_stat_watch;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] pin_n;
   logic       loop_en;
   logic [3:0] ctl_out;
   logic       rd_stb;
   logic [7:0] status;
   logic       irq;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   bit          done  = 1'b0;

   always #10 clk = ~clk;

   modem_stat_watch dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_n   (pin_n),
      .loop_en (loop_en),
      .ctl_out (ctl_out),
      .rd_stb  (rd_stb),
      .status  (status),
      .irq     (irq)
   );

   // Model built from the requirements: two sync stages, level register, flags
   logic [3:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_flag = '0;

   function automatic logic [3:0] events(input logic [3:0] prev, input logic [3:0] now);
      logic [3:0] e;
      e    = prev ^ now;
      e[2] = prev[2] & ~now[2];   // ring: only the falling level counts
      return e;
   endfunction

   always @(posedge clk) begin
      logic [3:0] lvl;
      lvl = loop_en ? ctl_out : ~m_s2;
      if (!rst_n) begin
         m_flag = '0;
         m_prev = lvl;
         m_s2   = pin_n;
         m_s1   = pin_n;
      end else begin
         m_flag = rd_stb ? events(m_prev, lvl) : (m_flag | events(m_prev, lvl));
         m_prev = lvl;
         m_s2   = m_s1;
         m_s1   = pin_n;
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read_pulse();
      rd_stb = 1'b1;
      tick(1);
      rd_stb = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; pin_n = 4'b0110; loop_en = 1'b0; ctl_out = 4'b0000; rd_stb = 1'b0;
      tick(3);
      chk("R9 flags during reset", {4'b0, status[3:0]}, 8'h00);
      rst_n = 1'b1;
      tick(4);
      chk("R9 after reset", status, 8'b1001_0000);
      chk("R9 irq after reset", {7'b0, irq}, 8'h00);

      // R1 latency and R3 on clear-to-send, level 1 -> 0
      pin_n = 4'b0111;
      tick(2);
      chk("R1 not yet visible", status, 8'b1001_0000);
      tick(1);
      chk("R1 R3 cts change", status, 8'b1000_0001);
      chk("R7 irq with flag", {7'b0, irq}, 8'h01);
      tick(5);
      chk("R10 sticky flag", status, 8'b1000_0001);
      read_pulse();
      chk("R5 read clears", status, 8'b1000_0000);
      chk("R7 irq cleared", {7'b0, irq}, 8'h00);

      // R3 opposite direction
      pin_n = 4'b0110;
      tick(3);
      chk("R3 cts back", status, 8'b1001_0001);
      read_pulse();

      // R4 ring: start of ring ignored, end of ring flagged
      pin_n = 4'b0010;
      tick(3);
      chk("R4 ring start ignored", status, 8'b1101_0000);
      chk("R4 irq low on ring start", {7'b0, irq}, 8'h00);
      pin_n = 4'b0110;
      tick(3);
      chk("R4 ring end flagged", status, 8'b1001_0100);
      read_pulse();

      // R3 two lines at once
      pin_n = 4'b1100;
      tick(3);
      chk("R3 dsr and dcd", status, 8'b0011_1010);
      read_pulse();
      chk("R5 cleared again", status, 8'b0011_0000);

      // R8 entering loop-back with equal sources: no flag
      ctl_out = 4'b0011; loop_en = 1'b1;
      tick(1);
      chk("R8 equal source no flag", status, 8'b0011_0000);
      ctl_out = 4'b1110;
      tick(1);
      chk("R2 loop follows ctl", status, 8'b1110_1001);

      // R6 change in the same cycle as the read
      ctl_out = 4'b1010; rd_stb = 1'b1;
      tick(1);
      rd_stb = 1'b0;
      chk("R6 event kept over read", status, 8'b1010_0100);

      // R8 leaving loop-back
      loop_en = 1'b0;
      tick(1);
      chk("R8 leave loopback", status, 8'b0011_1101);
      read_pulse();
      chk("R5 final clear", status, 8'b0011_0000);

      // Random phase against the model (R1 R2 R3 R4 R6 R7 R8)
      void'($urandom(32'd5150));
      for (int k = 0; k < 4000; k++) begin
         chk("R3 R4 R6 R8 random status", status, {m_prev, m_flag});
         chk("R7 random irq", {7'b0, irq}, {7'b0, |m_flag});
         if ($urandom_range(3) == 0) pin_n[$urandom_range(3)] ^= 1'b1;
         if ($urandom_range(4) == 0) ctl_out = 4'($urandom);
         if ($urandom_range(15) == 0) loop_en = ~loop_en;
         rd_stb = ($urandom_range(3) == 0);
         tick(1);
      end
      finish_run();
   end
endmodule